// File: doc/BRIEF.md
# Atomic Bank Reservation Tracker

This block guards memory banks that several bus masters share, so that a master can perform an atomic read-then-write sequence on a bank without interference. A master opens a reservation by issuing a read flagged as atomic to a bank nobody holds. From then on, requests from any other master to that bank are refused: the `grant_ok` output drops, and the arbiter next to this block must not grant them. The owning master may keep reading the bank freely. It closes the reservation by writing to the same bank.

Each bank has its own owner register, held flag and cycle counter, so several banks can be held at the same time by different masters. A reservation that the owner does not close within 256 clock cycles is dropped by force. If error reporting is enabled in the cycle of that drop, the block raises a one-cycle error pulse, sets a sticky error flag and records the bank that timed out. Choosing among competing requests is left to the surrounding arbiter. This block only says whether the current request may be granted.

Top module: `atom_resv_tracker`

## Requirements
- R1: While a bank is held, a request to it from any other master sees `grant_ok` low in the same cycle, and it leaves every bank's owner unchanged.
- R2: A write from the owner to its held bank is granted and frees the bank, so a request from another master to that bank is granted from the next cycle on.
- R3: Reads from the owner to its held bank are granted, whether or not they are flagged atomic, and the bank stays held by the same owner.
- R4: A reservation created at a clock edge still blocks other masters in each of the 256 cycles that follow that edge. It is cleared at the end of the 256th cycle, so another master is granted in the 257th.
- R5: When a reservation is dropped by timeout while `err_en` is 1 in that last cycle, `err_pulse` is 1 for exactly the next cycle, `err_sticky` becomes 1 and stays 1 until reset, and `err_bank` shows the number of the bank that timed out. When `err_en` is 0 in that cycle there is no pulse and the sticky flag does not change.
- R6: A write from a non-owner to a held bank is refused and does not free the bank.
- R7: An atomic read from a non-owner to a held bank is refused and does not take over the bank. After the owner frees the bank, the same request is granted and reserves it.
- R8: Reservations on different banks, by different masters, are kept and released independently of one another.
- R9: If the owner writes to its bank in the 256th cycle of the reservation, this is a normal release, and no error is reported.
- R10: A reservation is created only by a read (`req_write` = 0) with `req_atomic` = 1 to a free bank. A plain read, or a write flagged atomic, to a free bank is granted and reserves nothing.
- R11: After reset no bank is held and `grant_ok`, `err_pulse` and `err_sticky` are 0. `grant_ok` is 0 in every cycle in which `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_master | input | MASTER_W (2) | Identifier of the requesting master |
| req_bank | input | BANK_W (3) | Bank addressed by the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_atomic | input | 1 | Read is flagged atomic (opens a reservation) |
| err_en | input | 1 | Enables error reporting for timeouts |
| grant_ok | output | 1 | The current request may be granted (combinational) |
| err_pulse | output | 1 | One-cycle pulse after a reported timeout |
| err_sticky | output | 1 | Set by a reported timeout, cleared only by reset |
| err_bank | output | BANK_W (3) | Bank of the most recent reported timeout |

## Verification
The bench checks one bank's reservation against every kind of request that can reach it: owner reads (plain and atomic), owner writes, and non-owner reads, atomic reads and writes. These patterns separate a design that releases on any write from one that checks the owner, and one that re-arms on an owner read from one that leaves the reservation alone. Two banks held by different masters are then interleaved, which shows whether a release or a timeout leaks across banks. The timeout is tried with reporting on and with reporting off, and with an owner write landing exactly in the last cycle of the window. These runs pin down where the 256-cycle window ends and whether release or expiry wins in that last cycle. Plain reads and atomic writes to free banks confirm that neither one opens a reservation.

// File: rtl/atom_resv_pkg.sv
package atom_resv_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_CREATE  = 2'd1,
        ACT_RELEASE = 2'd2,
        ACT_EXPIRE  = 2'd3
    } slot_act_e;

    // Priority: owner write release beats expiry; creation only on a free bank.
    function automatic slot_act_e slot_action(
        input logic held,
        input logic owner_match,
        input logic hit,
        input logic is_write,
        input logic is_atomic,
        input logic at_limit
    );
        if (hit && held && owner_match && is_write)
            return ACT_RELEASE;
        else if (held && at_limit)
            return ACT_EXPIRE;
        else if (hit && !held && !is_write && is_atomic)
            return ACT_CREATE;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/atom_resv_slot.sv
module atom_resv_slot
    import atom_resv_pkg::*;
#(
    parameter int MASTER_W = 2,
    parameter int TIMEOUT  = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit,
    input  logic [MASTER_W-1:0] req_master,
    input  logic                req_write,
    input  logic                req_atomic,
    output logic                held,
    output logic [MASTER_W-1:0] owner,
    output logic                expire
);
    localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0] age;
    slot_act_e        act;

    always_comb begin
        act = slot_action(held, owner == req_master, hit, req_write,
                          req_atomic, age == LAST_CNT);
    end

    assign expire = (act == ACT_EXPIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= 1'b0;
            owner <= '0;
            age   <= '0;
        end else begin
            case (act)
                ACT_CREATE: begin
                    held  <= 1'b1;
                    owner <= req_master;
                    age   <= '0;
                end
                ACT_RELEASE, ACT_EXPIRE: begin
                    held <= 1'b0;
                    age  <= '0;
                end
                default: begin
                    if (held) age <= age + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/atom_resv_err.sv
module atom_resv_err #(
    parameter int N_BANKS = 8,
    parameter int BANK_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_BANKS-1:0] expire_vec,
    input  logic               err_en,
    output logic               err_pulse,
    output logic               err_sticky,
    output logic [BANK_W-1:0]  err_bank
);
    logic [BANK_W-1:0] first_idx;
    logic              report;

    always_comb begin
        first_idx = '0;
        for (int i = N_BANKS - 1; i >= 0; i--) begin
            if (expire_vec[i]) first_idx = BANK_W'(i);
        end
    end

    assign report = err_en && (|expire_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse  <= 1'b0;
            err_sticky <= 1'b0;
            err_bank   <= '0;
        end else begin
            err_pulse <= report;
            if (report) begin
                err_sticky <= 1'b1;
                err_bank   <= first_idx;
            end
        end
    end
endmodule

// File: rtl/atom_resv_tracker.sv
module atom_resv_tracker
    import atom_resv_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int N_BANKS   = 8,
    parameter int TIMEOUT   = 256,
    parameter int MASTER_W  = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
    parameter int BANK_W    = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [MASTER_W-1:0] req_master,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic                req_write,
    input  logic                req_atomic,
    input  logic                err_en,
    output logic                grant_ok,
    output logic                err_pulse,
    output logic                err_sticky,
    output logic [BANK_W-1:0]   err_bank
);
    logic [N_BANKS-1:0]          bank_valid;
    logic [N_BANKS-1:0]          bank_expire;
    logic [MASTER_W-1:0]         owner_arr [N_BANKS];
    logic [N_BANKS*MASTER_W-1:0] owner_flat;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_slot
        atom_resv_slot #(
            .MASTER_W (MASTER_W),
            .TIMEOUT  (TIMEOUT)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .hit        (req_valid && (req_bank == BANK_W'(b))),
            .req_master (req_master),
            .req_write  (req_write),
            .req_atomic (req_atomic),
            .held       (bank_valid[b]),
            .owner      (owner_arr[b]),
            .expire     (bank_expire[b])
        );
        assign owner_flat[b*MASTER_W +: MASTER_W] = owner_arr[b];
    end

    assign grant_ok = req_valid &&
                      !(bank_valid[req_bank] && (owner_arr[req_bank] != req_master));

    atom_resv_err #(
        .N_BANKS (N_BANKS),
        .BANK_W  (BANK_W)
    ) u_err (
        .clk        (clk),
        .rst        (rst),
        .expire_vec (bank_expire),
        .err_en     (err_en),
        .err_pulse  (err_pulse),
        .err_sticky (err_sticky),
        .err_bank   (err_bank)
    );
endmodule

// File: rtl/atom_resv_checker.sv
module atom_resv_checker #(
    parameter int N_BANKS  = 8,
    parameter int MASTER_W = 2,
    parameter int BANK_W   = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic [BANK_W-1:0]           req_bank,
    input logic                        req_write,
    input logic                        err_en,
    input logic                        grant_ok,
    input logic                        err_pulse,
    input logic                        err_sticky,
    input logic [N_BANKS-1:0]          bank_valid,
    input logic [N_BANKS*MASTER_W-1:0] owner_flat
);
    p_blocked_keeps_owner_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !grant_ok) |=> $stable(owner_flat));

    p_owner_write_frees_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && grant_ok && bank_valid[req_bank])
        |=> !bank_valid[$past(req_bank)]);

    p_write_never_reserves_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> ((bank_valid & ~$past(bank_valid)) == '0));

    p_pulse_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(err_en));

    p_pulse_sets_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky);

    p_sticky_holds_r5: assert property (@(posedge clk) disable iff (rst)
        $past(err_sticky) |-> err_sticky);

    p_grant_needs_request_r11: assert property (@(posedge clk) disable iff (rst)
        grant_ok |-> req_valid);
endmodule

bind atom_resv_tracker atom_resv_checker #(
    .N_BANKS  (N_BANKS),
    .MASTER_W (MASTER_W),
    .BANK_W   (BANK_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_bank   (req_bank),
    .req_write  (req_write),
    .err_en     (err_en),
    .grant_ok   (grant_ok),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky),
    .bank_valid (bank_valid),
    .owner_flat (owner_flat)
);

// File: tb/test_atom_resv_tracker.sv
`timescale 1ns/1ps
module test_atom_resv_tracker;
    localparam int NB = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_master = '0;
    logic [2:0] req_bank = '0;
    logic       req_write = 1'b0;
    logic       req_atomic = 1'b0;
    logic       err_en = 1'b0;
    logic       grant_ok, err_pulse, err_sticky;
    logic [2:0] err_bank;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    atom_resv_tracker i_atom_resv_tracker (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_master(req_master),
        .req_bank(req_bank), .req_write(req_write), .req_atomic(req_atomic),
        .err_en(err_en), .grant_ok(grant_ok), .err_pulse(err_pulse),
        .err_sticky(err_sticky), .err_bank(err_bank)
    );

    typedef struct {
        bit       g;
        bit       p;
        bit       s;
        bit [2:0] b;
        string    tag;
    } exp_t;
    exp_t q[$];

    // reference model built from the requirements
    bit       mv[NB];
    int       mo[NB];
    int       mc[NB];
    bit       m_pulse = 0;
    bit       m_sticky = 0;
    bit [2:0] m_bank = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic step(input bit v, input int m, input int b, input bit w,
                        input bit a, input string tag);
        bit any;
        int nb;
        exp_t e;
        @(negedge clk);
        req_valid  = v;
        req_master = 2'(m);
        req_bank   = 3'(b);
        req_write  = w;
        req_atomic = a;
        e.g = v && !(mv[b] && mo[b] != m);
        e.p = m_pulse;
        e.s = m_sticky;
        e.b = m_bank;
        e.tag = tag;
        q.push_back(e);
        any = 0;
        nb = 0;
        for (int i = NB - 1; i >= 0; i--) begin
            bit hit;
            hit = v && (b == i);
            if (hit && mv[i] && mo[i] == m && w) mv[i] = 0;
            else if (mv[i] && mc[i] == 255) begin mv[i] = 0; any = 1; nb = i; end
            else if (hit && !mv[i] && !w && a) begin mv[i] = 1; mo[i] = m; mc[i] = 0; end
            else if (mv[i]) mc[i]++;
        end
        m_pulse = err_en && any;
        if (m_pulse) begin m_sticky = 1; m_bank = 3'(nb); end
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, tag);
    endtask

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(grant_ok === e.g, e.tag, "grant_ok", grant_ok, e.g);
                check(err_pulse === e.p, e.tag, "err_pulse", err_pulse, e.p);
                check(err_sticky === e.s, e.tag, "err_sticky", err_sticky, e.s);
                if (e.s) check(err_bank === e.b, e.tag, "err_bank", err_bank, e.b);
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin mv[i] = 0; mo[i] = 0; mc[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R11 reset state
        check(grant_ok === 1'b0, "R11", "grant_ok", grant_ok, 0);
        check(err_pulse === 1'b0, "R11", "err_pulse", err_pulse, 0);
        check(err_sticky === 1'b0, "R11", "err_sticky", err_sticky, 0);

        err_en = 1'b1;
        // R10 plain read and atomic write do not reserve
        step(1, 0, 2, 0, 0, "R10");
        step(1, 1, 2, 0, 0, "R10");
        step(1, 0, 2, 1, 1, "R10");
        step(1, 1, 2, 0, 0, "R10");
        // R1 / R6 / R3 / R2 on bank 2 held by master 0
        step(1, 0, 2, 0, 1, "R10");
        step(1, 1, 2, 0, 0, "R1");
        step(1, 1, 2, 1, 0, "R6");
        step(1, 3, 2, 0, 0, "R6");
        step(1, 0, 2, 0, 0, "R3");
        step(1, 0, 2, 0, 1, "R3");
        step(1, 2, 2, 0, 0, "R3");
        step(1, 0, 2, 1, 0, "R2");
        step(1, 1, 2, 0, 0, "R2");
        step(0, 1, 2, 0, 0, "R11");
        // R7 atomic read from non-owner is blocked until release
        step(1, 2, 4, 0, 1, "R7");
        step(1, 1, 4, 0, 1, "R7");
        step(1, 2, 4, 0, 0, "R7");
        step(1, 2, 4, 1, 0, "R7");
        step(1, 1, 4, 0, 1, "R7");
        step(1, 2, 4, 0, 0, "R7");
        // R8 two banks held at once, released independently
        step(1, 3, 5, 0, 1, "R8");
        step(1, 2, 5, 0, 0, "R8");
        step(1, 3, 4, 0, 0, "R8");
        step(1, 1, 4, 1, 0, "R8");
        step(1, 3, 4, 0, 0, "R8");
        step(1, 0, 5, 0, 0, "R8");
        step(1, 3, 5, 1, 0, "R8");
        step(1, 0, 5, 0, 0, "R8");
        step(1, 0, 4, 0, 0, "R8");
        step(1, 1, 4, 1, 0, "R8");
        // R5 timeout with reporting disabled: no error
        err_en = 1'b0;
        step(1, 3, 1, 0, 1, "R5");
        for (int k = 0; k < 256; k++) step(1, 0, 1, 0, 0, "R4");
        step(1, 0, 1, 0, 0, "R4");
        idle(2, "R5");
        // R9 owner write in the final cycle wins
        err_en = 1'b1;
        step(1, 2, 6, 0, 1, "R9");
        idle(255, "R9");
        step(1, 2, 6, 1, 0, "R9");
        step(1, 0, 6, 0, 0, "R9");
        idle(2, "R9");
        // R4 / R5 timeout with reporting enabled on bank 5
        step(1, 1, 5, 0, 1, "R4");
        for (int k = 0; k < 256; k++) step(1, 2, 5, 0, 0, "R4");
        step(1, 2, 5, 0, 0, "R5");
        idle(3, "R5");
        // R5 sticky survives later traffic; the old owner's write is now ordinary
        step(1, 1, 5, 1, 0, "R5");
        step(1, 0, 3, 0, 1, "R5");
        step(1, 0, 3, 1, 0, "R5");
        idle(2, "R5");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule